// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core's memory pipeline which older in-flight store a load or store should wait for. It keeps two linked tables. The set table is indexed by instruction address and holds a store-set number plus a valid bit. The last-store table is indexed by that set number and holds the sequence number of the most recently inserted store of the set, also with a valid bit. Sets are learned from reported ordering violations. Each set's last-store entry is dropped again when that store issues or is squashed.

A dependence lookup is purely combinational on the instruction address and returns a store sequence number, or zero when there is no dependence. All table updates are synchronous. At most one update is applied per cycle, chosen by a fixed priority. A small tracker holds the stores that have been inserted with a valid set and have not yet issued or been squashed. Each tracked store is tagged with its thread, so that a per-thread squash can drop them and clean up their last-store entries.

Top module: `mdp_storeset`

## Requirements
- R1: The set-table index is bits `[PC_SHIFT +: log2(IDX_DEPTH)]` of the address (default bits 7:2). A fresh set number is `(pc ^ (pc >> 10)) mod SET_DEPTH`, taken from the store address of the violation. Addresses that share an index share an entry, and addresses whose fresh numbers match share a set.
- R2: `look_seq_o` equals the last-store sequence number of the looked-up address's set when both its set entry and that last-store entry are valid, and is 0 otherwise.
- R3: On a violation, if neither address has a valid set, both receive the fresh number from R1. If exactly one has a valid set, the other adopts it. If both have valid sets, both take the numerically smaller one. Both entries are valid afterwards.
- R4: A store insert writes its sequence number into the last-store entry of its set, and marks it valid, only when the store address has a valid set entry. Otherwise the insert changes nothing that a lookup can see.
- R5: A store issue invalidates the last-store entry of the issuing address's set only if that entry still holds the issuing sequence number. A load issue, or a store issue whose number does not match, leaves all tables unchanged. A store issue also stops tracking the store with that sequence number.
- R6: A squash with a thread and a sequence number stops tracking every store of that thread whose sequence number is strictly greater than the given one. Each such store's last-store entry is invalidated if it still holds that store's number. Stores of other threads, and stores with an equal or smaller number, are untouched. At most TRACK_DEPTH stores are tracked, and a store inserted while the tracker is full is written to the table but not tracked.
- R7: Reset and `clear_i` invalidate every entry of both tables and the tracker, so every lookup afterwards returns 0.
- R8: Updates take effect at the next clock edge, so a lookup in the same cycle as an update sees the old state. When several update requests arrive in one cycle, only the highest-priority one is applied, in the order clear, squash, violation, issue, insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Invalidate all tables |
| vio_valid_i | input | 1 | Violation report valid |
| vio_store_pc_i | input | PC_W | Address of the older store in the violation |
| vio_load_pc_i | input | PC_W | Address of the younger load in the violation |
| ins_valid_i | input | 1 | Store insert valid |
| ins_pc_i | input | PC_W | Inserted store address |
| ins_seq_i | input | SEQ_W | Inserted store sequence number |
| ins_tid_i | input | TID_W | Inserted store thread |
| look_pc_i | input | PC_W | Lookup address |
| look_seq_o | output | SEQ_W | Store to wait for, 0 if none |
| iss_valid_i | input | 1 | Issue notification valid |
| iss_pc_i | input | PC_W | Issuing instruction address |
| iss_seq_i | input | SEQ_W | Issuing instruction sequence number |
| iss_store_i | input | 1 | Issuing instruction is a store |
| sq_valid_i | input | 1 | Squash valid |
| sq_tid_i | input | TID_W | Thread being squashed |
| sq_seq_i | input | SEQ_W | Squash boundary; younger stores are dropped |

## Verification
The hardest case to reach from the ports is a set merge where both addresses already hold different valid sets. This needs two earlier independent violations that produced different fresh numbers, followed by a third that links them. The stimulus sets it up directly, using addresses picked so that their fresh numbers are known. It also draws random addresses from a small pool whose members alias in the index but differ in the bits that feed the hash. A second hard case is a squash that must invalidate an entry a later insert has not overwritten. This is reached by inserting on two threads and squashing each separately, both at and just below the tracked number. Random traffic then mixes simultaneous requests, so that the priority order is exercised against a bench model.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_CLEAR,
      OP_SQUASH,
      OP_TRAIN,
      OP_ISSUE,
      OP_FILL
   } op_e;

   // fold used to mint a fresh set number from a store address
   function automatic logic [63:0] fold_pc(input logic [63:0] pc);
      return pc ^ (pc >> 10);
   endfunction

endpackage

// File: rtl/mdp_set_table.sv
module mdp_set_table #(
   parameter int IDX_W = 6,
   parameter int SET_W = 4,
   parameter int N_RD  = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clr,
   input  logic                               train,
   input  logic [IDX_W-1:0]                   st_idx,
   input  logic [IDX_W-1:0]                   ld_idx,
   input  logic [SET_W-1:0]                   fresh_set,
   input  logic [N_RD-1:0][IDX_W-1:0]         rd_idx,
   output logic [N_RD-1:0]                    rd_vld,
   output logic [N_RD-1:0][SET_W-1:0]         rd_set,
   output logic [(1<<IDX_W)-1:0]              tab_vld,
   output logic [(1<<IDX_W)-1:0][SET_W-1:0]   tab_set
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0]            vld_q;
   logic [DEPTH-1:0][SET_W-1:0] set_q;
   logic                        st_v, ld_v;
   logic [SET_W-1:0]            st_s, ld_s, merged;

   assign st_v = vld_q[st_idx];
   assign ld_v = vld_q[ld_idx];
   assign st_s = set_q[st_idx];
   assign ld_s = set_q[ld_idx];

   always_comb begin
      unique case ({st_v, ld_v})
         2'b00:   merged = fresh_set;
         2'b10:   merged = st_s;
         2'b01:   merged = ld_s;
         default: merged = (st_s < ld_s) ? st_s : ld_s;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr) begin
         vld_q <= '0;
      end else if (train) begin
         vld_q[st_idx] <= 1'b1;
         vld_q[ld_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (train) begin
         set_q[st_idx] <= merged;
         set_q[ld_idx] <= merged;
      end
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rd_vld[p] = vld_q[rd_idx[p]];
      assign rd_set[p] = set_q[rd_idx[p]];
   end

   assign tab_vld = vld_q;
   assign tab_set = set_q;

endmodule

// File: rtl/mdp_last_table.sv
module mdp_last_table #(
   parameter int SET_W = 4,
   parameter int SEQ_W = 16,
   parameter int KILLS = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic                              wr,
   input  logic [SET_W-1:0]                  wr_set,
   input  logic [SEQ_W-1:0]                  wr_seq,
   input  logic                              inv,
   input  logic [SET_W-1:0]                  inv_set,
   input  logic [SEQ_W-1:0]                  inv_seq,
   input  logic [KILLS-1:0]                  kill_vld,
   input  logic [KILLS-1:0][SET_W-1:0]       kill_set,
   input  logic [KILLS-1:0][SEQ_W-1:0]       kill_seq,
   input  logic [SET_W-1:0]                  rd_set,
   output logic                              rd_vld,
   output logic [SEQ_W-1:0]                  rd_seq,
   output logic [(1<<SET_W)-1:0]             tab_vld,
   output logic [(1<<SET_W)-1:0][SEQ_W-1:0]  tab_seq
);
   localparam int DEPTH = 1 << SET_W;

   logic [DEPTH-1:0]            vld_q, drop;
   logic [DEPTH-1:0][SEQ_W-1:0] seq_q;

   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         drop[j] = inv && (inv_set == SET_W'(j)) && (seq_q[j] == inv_seq);
         for (int k = 0; k < KILLS; k++) begin
            if (kill_vld[k] && (kill_set[k] == SET_W'(j)) && (seq_q[j] == kill_seq[k]))
               drop[j] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr) begin
         vld_q <= '0;
      end else begin
         for (int j = 0; j < DEPTH; j++) begin
            if (wr && (wr_set == SET_W'(j))) vld_q[j] <= 1'b1;
            else if (drop[j])                vld_q[j] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr) seq_q[wr_set] <= wr_seq;
   end

   assign rd_vld  = vld_q[rd_set];
   assign rd_seq  = seq_q[rd_set];
   assign tab_vld = vld_q;
   assign tab_seq = seq_q;

endmodule

// File: rtl/mdp_inflight.sv
module mdp_inflight #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   parameter int SET_W = 4,
   parameter int TID_W = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          add,
   input  logic [SEQ_W-1:0]              add_seq,
   input  logic [SET_W-1:0]              add_set,
   input  logic [TID_W-1:0]              add_tid,
   input  logic                          retire,
   input  logic [SEQ_W-1:0]              retire_seq,
   input  logic                          squash,
   input  logic [TID_W-1:0]              sq_tid,
   input  logic [SEQ_W-1:0]              sq_seq,
   output logic [DEPTH-1:0]              kill_vld,
   output logic [DEPTH-1:0][SET_W-1:0]   kill_set,
   output logic [DEPTH-1:0][SEQ_W-1:0]   kill_seq
);
   localparam int SLOT_W = $clog2(DEPTH);

   logic [DEPTH-1:0]            vld_q, gone;
   logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
   logic [DEPTH-1:0][SET_W-1:0] set_q;
   logic [DEPTH-1:0][TID_W-1:0] tid_q;
   logic [SLOT_W-1:0]           slot;
   logic                        found;

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      assign kill_vld[k] = squash && vld_q[k] && (tid_q[k] == sq_tid) && (seq_q[k] > sq_seq);
      assign gone[k]     = kill_vld[k] || (retire && vld_q[k] && (seq_q[k] == retire_seq));
      assign kill_set[k] = set_q[k];
      assign kill_seq[k] = seq_q[k];
   end

   always_comb begin
      found = 1'b0;
      slot  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (!vld_q[k] && !found) begin
            found = 1'b1;
            slot  = SLOT_W'(k);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr) begin
         vld_q <= '0;
      end else begin
         vld_q <= vld_q & ~gone;
         if (add && found) vld_q[slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (add && found) begin
         seq_q[slot] <= add_seq;
         set_q[slot] <= add_set;
         tid_q[slot] <= add_tid;
      end
   end

endmodule

// File: rtl/mdp_storeset.sv
module mdp_storeset
   import mdp_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int SEQ_W       = 16,
   parameter int TID_W       = 1,
   parameter int IDX_DEPTH   = 64,
   parameter int SET_DEPTH   = 16,
   parameter int PC_SHIFT    = 2,
   parameter int TRACK_DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             vio_valid_i,
   input  logic [PC_W-1:0]  vio_store_pc_i,
   input  logic [PC_W-1:0]  vio_load_pc_i,
   input  logic             ins_valid_i,
   input  logic [PC_W-1:0]  ins_pc_i,
   input  logic [SEQ_W-1:0] ins_seq_i,
   input  logic [TID_W-1:0] ins_tid_i,
   input  logic [PC_W-1:0]  look_pc_i,
   output logic [SEQ_W-1:0] look_seq_o,
   input  logic             iss_valid_i,
   input  logic [PC_W-1:0]  iss_pc_i,
   input  logic [SEQ_W-1:0] iss_seq_i,
   input  logic             iss_store_i,
   input  logic             sq_valid_i,
   input  logic [TID_W-1:0] sq_tid_i,
   input  logic [SEQ_W-1:0] sq_seq_i
);
   localparam int IDX_W = $clog2(IDX_DEPTH);
   localparam int SET_W = $clog2(SET_DEPTH);

   if ((1 << IDX_W) != IDX_DEPTH || IDX_W < 1) begin : g_bad_idx
      $error("IDX_DEPTH must be a power of two of at least 2");
   end
   if ((1 << SET_W) != SET_DEPTH || SET_W < 1) begin : g_bad_set
      $error("SET_DEPTH must be a power of two of at least 2");
   end
   if (PC_W > 64 || PC_W < PC_SHIFT + IDX_W) begin : g_bad_pc
      $error("PC_W must hold the index field and not exceed 64");
   end
   if (TRACK_DEPTH < 2) begin : g_bad_trk
      $error("TRACK_DEPTH must be at least 2");
   end

   op_e op;
   always_comb begin
      if      (clear_i)     op = OP_CLEAR;
      else if (sq_valid_i)  op = OP_SQUASH;
      else if (vio_valid_i) op = OP_TRAIN;
      else if (iss_valid_i) op = OP_ISSUE;
      else if (ins_valid_i) op = OP_FILL;
      else                  op = OP_IDLE;
   end

   logic [IDX_W-1:0] vs_idx, vl_idx, lk_idx, ins_idx, iss_idx;
   assign vs_idx  = vio_store_pc_i[PC_SHIFT +: IDX_W];
   assign vl_idx  = vio_load_pc_i[PC_SHIFT +: IDX_W];
   assign lk_idx  = look_pc_i[PC_SHIFT +: IDX_W];
   assign ins_idx = ins_pc_i[PC_SHIFT +: IDX_W];
   assign iss_idx = iss_pc_i[PC_SHIFT +: IDX_W];

   logic [63:0]      folded;
   logic [SET_W-1:0] fresh_set;
   assign folded    = fold_pc(64'(vio_store_pc_i));
   assign fresh_set = folded[SET_W-1:0];

   logic [2:0]                        rd_vld;
   logic [2:0][SET_W-1:0]             rd_set;
   logic [IDX_DEPTH-1:0]              idt_vld;
   logic [IDX_DEPTH-1:0][SET_W-1:0]   idt_set;

   mdp_set_table #(.IDX_W(IDX_W), .SET_W(SET_W), .N_RD(3)) u_sets (
      .clk(clk), .rst_n(rst_n),
      .clr(op == OP_CLEAR), .train(op == OP_TRAIN),
      .st_idx(vs_idx), .ld_idx(vl_idx), .fresh_set(fresh_set),
      .rd_idx({iss_idx, ins_idx, lk_idx}),
      .rd_vld(rd_vld), .rd_set(rd_set),
      .tab_vld(idt_vld), .tab_set(idt_set)
   );

   logic             lk_idv, ins_idv, iss_idv;
   logic [SET_W-1:0] lk_set, ins_set, iss_set;
   assign lk_idv  = rd_vld[0];
   assign lk_set  = rd_set[0];
   assign ins_idv = rd_vld[1];
   assign ins_set = rd_set[1];
   assign iss_idv = rd_vld[2];
   assign iss_set = rd_set[2];

   logic [TRACK_DEPTH-1:0]            kill_vld;
   logic [TRACK_DEPTH-1:0][SET_W-1:0] kill_set;
   logic [TRACK_DEPTH-1:0][SEQ_W-1:0] kill_seq;

   mdp_inflight #(.DEPTH(TRACK_DEPTH), .SEQ_W(SEQ_W), .SET_W(SET_W), .TID_W(TID_W)) u_track (
      .clk(clk), .rst_n(rst_n), .clr(op == OP_CLEAR),
      .add(op == OP_FILL && ins_idv), .add_seq(ins_seq_i), .add_set(ins_set), .add_tid(ins_tid_i),
      .retire(op == OP_ISSUE && iss_store_i), .retire_seq(iss_seq_i),
      .squash(op == OP_SQUASH), .sq_tid(sq_tid_i), .sq_seq(sq_seq_i),
      .kill_vld(kill_vld), .kill_set(kill_set), .kill_seq(kill_seq)
   );

   logic                              lk_lvld;
   logic [SEQ_W-1:0]                  lk_seq;
   logic [SET_DEPTH-1:0]              lst_vld;
   logic [SET_DEPTH-1:0][SEQ_W-1:0]   lst_seq;

   mdp_last_table #(.SET_W(SET_W), .SEQ_W(SEQ_W), .KILLS(TRACK_DEPTH)) u_last (
      .clk(clk), .rst_n(rst_n), .clr(op == OP_CLEAR),
      .wr(op == OP_FILL && ins_idv), .wr_set(ins_set), .wr_seq(ins_seq_i),
      .inv(op == OP_ISSUE && iss_store_i && iss_idv), .inv_set(iss_set), .inv_seq(iss_seq_i),
      .kill_vld(kill_vld), .kill_set(kill_set), .kill_seq(kill_seq),
      .rd_set(lk_set), .rd_vld(lk_lvld), .rd_seq(lk_seq),
      .tab_vld(lst_vld), .tab_seq(lst_seq)
   );

   assign look_seq_o = (lk_idv && lk_lvld) ? lk_seq : '0;

endmodule

// File: rtl/mdp_storeset_chk.sv
module mdp_storeset_chk
   import mdp_pkg::*;
#(
   parameter int SEQ_W     = 16,
   parameter int IDX_DEPTH = 64,
   parameter int SET_DEPTH = 16
) (
   input logic                                          clk,
   input logic                                          rst_n,
   input logic                                          clear_i,
   input logic                                          iss_store_i,
   input logic [SEQ_W-1:0]                              iss_seq_i,
   input logic [SEQ_W-1:0]                              ins_seq_i,
   input logic [SEQ_W-1:0]                              look_seq_o,
   input op_e                                           op,
   input logic                                          ins_idv,
   input logic [$clog2(SET_DEPTH)-1:0]                  ins_set,
   input logic                                          iss_idv,
   input logic [$clog2(SET_DEPTH)-1:0]                  iss_set,
   input logic [$clog2(IDX_DEPTH)-1:0]                  vs_idx,
   input logic [$clog2(IDX_DEPTH)-1:0]                  vl_idx,
   input logic [IDX_DEPTH-1:0]                          idt_vld,
   input logic [IDX_DEPTH-1:0][$clog2(SET_DEPTH)-1:0]   idt_set,
   input logic [SET_DEPTH-1:0]                          lst_vld,
   input logic [SET_DEPTH-1:0][SEQ_W-1:0]               lst_seq
);

   // R7
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (look_seq_o == '0));

   // R3
   train_joins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_TRAIN) |=> (idt_vld[$past(vs_idx)] && idt_vld[$past(vl_idx)] &&
                            idt_set[$past(vs_idx)] == idt_set[$past(vl_idx)]));

   // R4
   fill_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FILL && ins_idv) |=> (lst_vld[$past(ins_set)] &&
                                      lst_seq[$past(ins_set)] == $past(ins_seq_i)));

   // R4
   fill_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FILL && !ins_idv) |=> $stable(lst_vld));

   // R5
   load_issue_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ISSUE && !iss_store_i) |=> ($stable(lst_vld) && $stable(idt_vld)));

   // R5
   store_issue_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ISSUE && iss_store_i && iss_idv && lst_vld[iss_set] &&
       lst_seq[iss_set] == iss_seq_i) |=> !lst_vld[$past(iss_set)]);

endmodule

bind mdp_storeset mdp_storeset_chk #(
   .SEQ_W(SEQ_W), .IDX_DEPTH(IDX_DEPTH), .SET_DEPTH(SET_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
   .iss_store_i(iss_store_i), .iss_seq_i(iss_seq_i), .ins_seq_i(ins_seq_i),
   .look_seq_o(look_seq_o), .op(op),
   .ins_idv(ins_idv), .ins_set(ins_set), .iss_idv(iss_idv), .iss_set(iss_set),
   .vs_idx(vs_idx), .vl_idx(vl_idx),
   .idt_vld(idt_vld), .idt_set(idt_set), .lst_vld(lst_vld), .lst_seq(lst_seq)
);

// File: tb/mdp_storeset_bench.sv
module mdp_storeset_bench;
   localparam int PC_W = 32, SEQ_W = 16, TID_W = 1;
   localparam int IDX_DEPTH = 64, SET_DEPTH = 16, PC_SHIFT = 2, TRACK_DEPTH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic clear_i = 0, vio_valid_i = 0, ins_valid_i = 0, iss_valid_i = 0, iss_store_i = 0, sq_valid_i = 0;
   logic [PC_W-1:0]  vio_store_pc_i = '0, vio_load_pc_i = '0, ins_pc_i = '0, look_pc_i = '0, iss_pc_i = '0;
   logic [SEQ_W-1:0] ins_seq_i = '0, iss_seq_i = '0, sq_seq_i = '0;
   logic [TID_W-1:0] ins_tid_i = '0, sq_tid_i = '0;
   logic [SEQ_W-1:0] look_seq_o;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   mdp_storeset u_mdp_storeset (.*);

   // ---------------- reference model ----------------
   bit       m_iv [IDX_DEPTH];
   int       m_is [IDX_DEPTH];
   bit       m_lv [SET_DEPTH];
   int       m_ls [SET_DEPTH];
   bit       t_v  [TRACK_DEPTH];
   int       t_seq[TRACK_DEPTH];
   int       t_set[TRACK_DEPTH];
   int       t_tid[TRACK_DEPTH];

   function automatic int f_idx(logic [PC_W-1:0] pc);
      return int'((pc >> PC_SHIFT) % IDX_DEPTH);
   endfunction
   function automatic int f_fresh(logic [PC_W-1:0] pc);
      return int'((pc ^ (pc >> 10)) % SET_DEPTH);
   endfunction
   function automatic int exp_look(logic [PC_W-1:0] pc);
      int i = f_idx(pc);
      if (m_iv[i] && m_lv[m_is[i]]) return m_ls[m_is[i]];
      return 0;
   endfunction

   function automatic void model_clear();
      for (int i = 0; i < IDX_DEPTH; i++) m_iv[i] = 0;
      for (int j = 0; j < SET_DEPTH; j++) m_lv[j] = 0;
      for (int k = 0; k < TRACK_DEPTH; k++) t_v[k] = 0;
   endfunction

   function automatic void model_step();
      if (clear_i) begin
         model_clear();
      end else if (sq_valid_i) begin
         for (int k = 0; k < TRACK_DEPTH; k++)
            if (t_v[k] && t_tid[k] == int'(sq_tid_i) && t_seq[k] > int'(sq_seq_i)) begin
               if (m_lv[t_set[k]] && m_ls[t_set[k]] == t_seq[k]) m_lv[t_set[k]] = 0;
               t_v[k] = 0;
            end
      end else if (vio_valid_i) begin
         int si = f_idx(vio_store_pc_i), li = f_idx(vio_load_pc_i), m;
         if (!m_iv[si] && !m_iv[li]) m = f_fresh(vio_store_pc_i);
         else if (!m_iv[li])         m = m_is[si];
         else if (!m_iv[si])         m = m_is[li];
         else                        m = (m_is[si] < m_is[li]) ? m_is[si] : m_is[li];
         m_iv[si] = 1; m_is[si] = m; m_iv[li] = 1; m_is[li] = m;
      end else if (iss_valid_i) begin
         if (iss_store_i) begin
            int i = f_idx(iss_pc_i);
            if (m_iv[i] && m_lv[m_is[i]] && m_ls[m_is[i]] == int'(iss_seq_i)) m_lv[m_is[i]] = 0;
            for (int k = 0; k < TRACK_DEPTH; k++)
               if (t_v[k] && t_seq[k] == int'(iss_seq_i)) t_v[k] = 0;
         end
      end else if (ins_valid_i) begin
         int i = f_idx(ins_pc_i);
         if (m_iv[i]) begin
            bit placed = 0;
            m_lv[m_is[i]] = 1; m_ls[m_is[i]] = int'(ins_seq_i);
            for (int k = 0; k < TRACK_DEPTH; k++)
               if (!t_v[k] && !placed) begin
                  t_v[k] = 1; t_seq[k] = int'(ins_seq_i); t_set[k] = m_is[i];
                  t_tid[k] = int'(ins_tid_i); placed = 1;
               end
         end
      end
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic peek(logic [PC_W-1:0] pc, int exp, string req);
      look_pc_i = pc;
      #1;
      chk(req, int'(look_seq_o), exp);
      chk({req, " model"}, exp_look(pc), exp);
   endtask

   // one clock: lookup checked against the pre-edge state, then the edge
   task automatic tick(string req);
      #1;
      chk(req, int'(look_seq_o), exp_look(look_pc_i));
      @(posedge clk);
      model_step();
      @(negedge clk);
      clear_i = 0; vio_valid_i = 0; ins_valid_i = 0; iss_valid_i = 0; sq_valid_i = 0;
   endtask

   task automatic do_vio(logic [PC_W-1:0] s, logic [PC_W-1:0] l);
      vio_valid_i = 1; vio_store_pc_i = s; vio_load_pc_i = l; tick("R3");
   endtask
   task automatic do_ins(logic [PC_W-1:0] pc, int seq, int tid);
      ins_valid_i = 1; ins_pc_i = pc; ins_seq_i = SEQ_W'(seq); ins_tid_i = TID_W'(tid); tick("R4");
   endtask
   task automatic do_iss(logic [PC_W-1:0] pc, int seq, bit st);
      iss_valid_i = 1; iss_pc_i = pc; iss_seq_i = SEQ_W'(seq); iss_store_i = st; tick("R5");
   endtask
   task automatic do_sq(int tid, int seq);
      sq_valid_i = 1; sq_tid_i = TID_W'(tid); sq_seq_i = SEQ_W'(seq); tick("R6");
   endtask

   function automatic logic [PC_W-1:0] pool_pc(int unsigned r);
      return PC_W'(((r % 8) << 2) | (((r / 8) % 4) << 10) | (((r / 32) % 2) << 8));
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int unsigned      seed;
      int               nseq;
      logic [PC_W-1:0]  ring_pc [8];
      int               ring_seq[8];
      int               rp;
      seed = $urandom(32'd1234);
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R7 reset state
      peek(32'h40, 0, "R7");
      peek(32'h80, 0, "R7");
      // R4 insert with no valid set is ignored
      do_ins(32'h40, 3, 0);
      peek(32'h40, 0, "R4");
      // R3 both invalid -> fresh set, then R2 lookup
      do_vio(32'h40, 32'h80);
      do_ins(32'h40, 5, 0);
      peek(32'h80, 5, "R2");
      peek(32'h40, 5, "R2");
      // R1 colliding fresh number and index aliasing
      do_vio(32'h200, 32'h204);
      peek(32'h204, 5, "R1");
      peek(32'h140, 5, "R1");
      // R8 same-cycle insert and lookup sees old value
      ins_valid_i = 1; ins_pc_i = 32'h40; ins_seq_i = 9; ins_tid_i = 0;
      peek(32'h80, 5, "R8");
      tick("R8");
      peek(32'h80, 9, "R8");
      // R5 issue rules
      do_iss(32'h40, 5, 1);
      peek(32'h80, 9, "R5");
      do_iss(32'h80, 9, 0);
      peek(32'h80, 9, "R5");
      do_iss(32'h40, 9, 1);
      peek(32'h80, 0, "R5");
      // R6 squash rules
      do_ins(32'h40, 12, 1);
      do_sq(0, 10);
      peek(32'h80, 12, "R6");
      do_sq(1, 12);
      peek(32'h80, 12, "R6");
      do_sq(1, 11);
      peek(32'h80, 0, "R6");
      // R3 both valid -> smaller set; one valid -> adopt
      do_vio(32'h0C, 32'h30);
      do_vio(32'h40, 32'h30);
      do_ins(32'h40, 20, 0);
      peek(32'h30, 20, "R3");
      peek(32'h0C, 0, "R3");
      do_vio(32'h0C, 32'h50);
      do_ins(32'h0C, 21, 0);
      peek(32'h50, 21, "R3");
      // R8 priority: clear beats insert, violation beats insert
      clear_i = 1; ins_valid_i = 1; ins_pc_i = 32'h40; ins_seq_i = 25; tick("R8");
      peek(32'h40, 0, "R7");
      vio_valid_i = 1; vio_store_pc_i = 32'h40; vio_load_pc_i = 32'h80;
      ins_valid_i = 1; ins_pc_i = 32'h40; ins_seq_i = 30; tick("R8");
      peek(32'h80, 0, "R8");
      do_ins(32'h40, 31, 0);
      peek(32'h80, 31, "R8");
      clear_i = 1; tick("R7");

      // random traffic against the model
      nseq = 40; rp = 0;
      for (int k = 0; k < 8; k++) begin ring_pc[k] = pool_pc(k); ring_seq[k] = 1; end
      for (int n = 0; n < 4000; n++) begin
         int unsigned r = $urandom;
         clear_i     = (r % 200) == 0;
         sq_valid_i  = ((r >> 8) % 100) < 6;
         vio_valid_i = ((r >> 15) % 100) < 15;
         iss_valid_i = ((r >> 22) % 100) < 25;
         ins_valid_i = 1;
         sq_tid_i    = TID_W'($urandom % 2);
         sq_seq_i    = SEQ_W'(nseq - 1 - int'($urandom % 6));
         vio_store_pc_i = pool_pc($urandom);
         vio_load_pc_i  = pool_pc($urandom);
         begin
            int q = int'($urandom % 8);
            iss_pc_i    = ($urandom % 10 < 7) ? ring_pc[q] : pool_pc($urandom);
            iss_seq_i   = SEQ_W'(ring_seq[q]);
            iss_store_i = ($urandom % 100) < 85;
         end
         ins_pc_i  = pool_pc($urandom);
         ins_seq_i = SEQ_W'(nseq);
         ins_tid_i = TID_W'($urandom % 2);
         look_pc_i = pool_pc($urandom);
         if (!clear_i && !sq_valid_i && !vio_valid_i && !iss_valid_i) begin
            ring_pc[rp] = ins_pc_i; ring_seq[rp] = nseq; rp = (rp + 1) % 8;
         end
         nseq++;
         tick("R2");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule